// File: doc/BRIEF.md
# Timer Interrupt Flag Controller

This block keeps the pending-interrupt state of two timer/counters in one 8-bit status register. Timer1 contributes four sources: overflow, compare match A, compare match B and input capture. Timer0 contributes two: overflow and compare match. Each source is raised by a one-cycle event pulse from the timer datapath. In PWM mode the timer1 overflow flag is set by the counter turning around at zero instead of by a count wraparound.

Software clears a flag by writing a one to its bit. Writing a zero leaves the bit as it is. The CPU can also clear a flag by asserting a one-hot acknowledge for that vector while it services the interrupt. An 8-bit enable register uses the same bit layout as the status register. A flag, its enable bit and the global interrupt enable together form a per-source request. A fixed-priority arbiter then reports whether any request is pending and the vector index of the winner.

Top module: `tmr_irq_flags`

## Requirements
- R1: Bit layout of both the status and the enable register: bit 7 timer1 overflow, bit 6 compare A, bit 5 compare B, bit 3 input capture, bit 1 timer0 overflow, bit 0 timer0 compare. Bits 4 and 2 always read zero in both registers, whatever is written.
- R2: A one-cycle event pulse sets its flag, and the flag is visible in `flags` after the next rising clock edge.
- R3: With `pwm_mode` low, only `ev_t1_wrap` sets the timer1 overflow flag. With `pwm_mode` high, only `ev_t1_turn` sets it.
- R4: A write strobe on `flag_wr` clears every flag whose bit in `wr_data` is one. Flags whose bit is zero are unchanged.
- R5: A one-hot `vec_ack` clears only the flag of that vector. The vector indices are 0 capture, 1 compare A, 2 compare B, 3 timer1 overflow, 4 timer0 compare, 5 timer0 overflow.
- R6: When a set event and a clear (write-one or acknowledge) hit the same flag in the same cycle, the flag ends set.
- R7: `irq_req` bit n is one exactly when `gie`, enable bit n and flag bit n are all one. Its layout is that of R1.
- R8: `irq_pending` is high when any request is active. `irq_vec` then gives the lowest vector index among the active requests, with the indices of R5.
- R9: A synchronous active-high `rst` clears all flags and all enable bits.
- R10: A strobe on `en_wr` loads `wr_data` into the enable register, with reserved bits forced to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_mode | input | 1 | Selects the turn-at-zero event as the timer1 overflow source |
| ev_t1_wrap | input | 1 | Timer1 count wraparound pulse |
| ev_t1_turn | input | 1 | Timer1 direction change at zero pulse |
| ev_cmp_a | input | 1 | Timer1 compare A match pulse |
| ev_cmp_b | input | 1 | Timer1 compare B match pulse |
| ev_capture | input | 1 | Timer1 capture done pulse |
| ev_t0_wrap | input | 1 | Timer0 overflow pulse |
| ev_t0_cmp | input | 1 | Timer0 compare match pulse |
| flag_wr | input | 1 | Write strobe for the status register (write one to clear) |
| en_wr | input | 1 | Write strobe for the enable register |
| wr_data | input | 8 | Write data for both registers |
| gie | input | 1 | Global interrupt enable |
| vec_ack | input | 6 | One-hot vector acknowledge |
| flags | output | 8 | Status register contents |
| enables | output | 8 | Enable register contents |
| irq_req | output | 8 | Per-source interrupt requests |
| irq_pending | output | 1 | Any request active |
| irq_vec | output | VEC_W | Index of the winning vector |

## Verification
The bench uses the default `VEC_W` of 3, which is just wide enough for the six vector indices. At that size every one of the 64 combinations of pending flags can be swept against several enable patterns, with the global enable both low and high. The expected request vector and winning index are computed arithmetically for each combination. Each source is also driven through set, write-zero, write-one, acknowledge and same-cycle collision, one at a time.

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags #(
  parameter int VEC_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwm_mode,
  input  logic             ev_t1_wrap,
  input  logic             ev_t1_turn,
  input  logic             ev_cmp_a,
  input  logic             ev_cmp_b,
  input  logic             ev_capture,
  input  logic             ev_t0_wrap,
  input  logic             ev_t0_cmp,
  input  logic             flag_wr,
  input  logic             en_wr,
  input  logic [7:0]       wr_data,
  input  logic             gie,
  input  logic [5:0]       vec_ack,
  output logic [7:0]       flags,
  output logic [7:0]       enables,
  output logic [7:0]       irq_req,
  output logic             irq_pending,
  output logic [VEC_W-1:0] irq_vec
);
  localparam logic [7:0] LIVE = 8'b1110_1011;
  localparam int NSRC = 6;

  logic [7:0] flg_q, msk_q;
  logic       t1_ovf_ev;
  logic [7:0] set_l, ack_l, wclr;
  logic [NSRC-1:0] req_v;

  assign t1_ovf_ev = pwm_mode ? ev_t1_turn : ev_t1_wrap;
  assign set_l = {t1_ovf_ev, ev_cmp_a, ev_cmp_b, 1'b0, ev_capture, 1'b0, ev_t0_wrap, ev_t0_cmp};
  assign ack_l = {vec_ack[3], vec_ack[1], vec_ack[2], 1'b0, vec_ack[0], 1'b0, vec_ack[5], vec_ack[4]};
  assign wclr  = flag_wr ? wr_data : 8'h00;

  always_ff @(posedge clk) begin
    if (rst) begin
      flg_q <= 8'h00;
      msk_q <= 8'h00;
    end else begin
      flg_q <= LIVE & (set_l | (flg_q & ~wclr & ~ack_l));
      if (en_wr) msk_q <= LIVE & wr_data;
    end
  end

  assign flags   = flg_q;
  assign enables = msk_q;
  assign irq_req = {8{gie}} & msk_q & flg_q;
  assign req_v   = {irq_req[1], irq_req[0], irq_req[7], irq_req[5], irq_req[6], irq_req[3]};
  assign irq_pending = |req_v;

  always_comb begin
    irq_vec = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (req_v[i]) irq_vec = VEC_W'(i);
  end
endmodule

module tmr_irq_flags_chk #(
  parameter int VEC_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             gie,
  input logic             ev_capture,
  input logic             ev_cmp_a,
  input logic             flag_wr,
  input logic [7:0]       wr_data,
  input logic [5:0]       vec_ack,
  input logic [7:0]       flags,
  input logic [7:0]       enables,
  input logic [7:0]       irq_req,
  input logic             irq_pending,
  input logic [VEC_W-1:0] irq_vec
);
  p_resv_zero_r1: assert property (@(posedge clk) disable iff (rst)
    ((flags & 8'h14) == 8'h00) && ((enables & 8'h14) == 8'h00));

  p_capture_set_r2: assert property (@(posedge clk) disable iff (rst)
    ev_capture |=> flags[3]);

  p_w1c_r4: assert property (@(posedge clk) disable iff (rst)
    (flag_wr && wr_data[6] && !ev_cmp_a) |=> !flags[6]);

  p_ack_clr_r5: assert property (@(posedge clk) disable iff (rst)
    (vec_ack == 6'b000001 && !ev_capture) |=> !flags[3]);

  p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
    (ev_cmp_a && flag_wr && wr_data[6]) |=> flags[6]);

  p_req_gate_r7: assert property (@(posedge clk) disable iff (rst)
    ((irq_req & ~(flags & enables)) == 8'h00) && (!gie -> irq_req == 8'h00));

  p_top_vec_r8: assert property (@(posedge clk) disable iff (rst)
    irq_req[3] |-> (irq_pending && irq_vec == '0));

  p_pending_r8: assert property (@(posedge clk) disable iff (rst)
    irq_pending |-> (irq_req != 8'h00));

  p_reset_r9: assert property (@(posedge clk)
    rst |=> (flags == 8'h00 && enables == 8'h00));
endmodule

bind tmr_irq_flags tmr_irq_flags_chk #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst(rst), .gie(gie), .ev_capture(ev_capture), .ev_cmp_a(ev_cmp_a),
  .flag_wr(flag_wr), .wr_data(wr_data), .vec_ack(vec_ack), .flags(flags),
  .enables(enables), .irq_req(irq_req), .irq_pending(irq_pending), .irq_vec(irq_vec)
);

// File: tb/tmr_irq_flags_tb.sv
module tmr_irq_flags_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwm_mode = 0, ev_t1_wrap = 0, ev_t1_turn = 0, ev_cmp_a = 0, ev_cmp_b = 0;
  logic ev_capture = 0, ev_t0_wrap = 0, ev_t0_cmp = 0, flag_wr = 0, en_wr = 0, gie = 0;
  logic [7:0] wr_data = 8'h00;
  logic [5:0] vec_ack = 6'h00;
  logic [7:0] flags, enables, irq_req;
  logic       irq_pending;
  logic [2:0] irq_vec;
  int n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  tmr_irq_flags #(.VEC_W(3)) u_dut (
    .clk(clk), .rst(rst), .pwm_mode(pwm_mode), .ev_t1_wrap(ev_t1_wrap), .ev_t1_turn(ev_t1_turn),
    .ev_cmp_a(ev_cmp_a), .ev_cmp_b(ev_cmp_b), .ev_capture(ev_capture), .ev_t0_wrap(ev_t0_wrap),
    .ev_t0_cmp(ev_t0_cmp), .flag_wr(flag_wr), .en_wr(en_wr), .wr_data(wr_data), .gie(gie),
    .vec_ack(vec_ack), .flags(flags), .enables(enables), .irq_req(irq_req),
    .irq_pending(irq_pending), .irq_vec(irq_vec)
  );

  function automatic int pos_of(int v);
    case (v)
      0: return 3;
      1: return 6;
      2: return 5;
      3: return 7;
      4: return 0;
      default: return 1;
    endcase
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive_ev(logic [7:0] m);
    ev_t1_wrap = m[7] & ~pwm_mode;
    ev_t1_turn = m[7] & pwm_mode;
    ev_cmp_a = m[6]; ev_cmp_b = m[5]; ev_capture = m[3];
    ev_t0_wrap = m[1]; ev_t0_cmp = m[0];
  endtask

  task automatic pulse_ev(logic [7:0] m);
    drive_ev(m);
    tick();
    drive_ev(8'h00);
  endtask

  task automatic wr_flags(logic [7:0] d);
    flag_wr = 1; wr_data = d;
    tick();
    flag_wr = 0; wr_data = 8'h00;
  endtask

  task automatic wr_en(logic [7:0] d);
    en_wr = 1; wr_data = d;
    tick();
    en_wr = 0; wr_data = 8'h00;
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] acc;
    #1;
    tick(); tick();
    rst = 0;
    // R9 reset state
    chk("R9 flags", flags, 8'h00);
    chk("R9 enables", enables, 8'h00);
    chk("R9 pending", irq_pending, 0);

    // R10 / R1 enable load with reserved masking
    wr_en(8'hFF);
    chk("R10 R1 enables all", enables, 8'hEB);
    wr_en(8'h42);
    chk("R10 enables pattern", enables, 8'h42);

    // R2 / R4 per source
    for (int v = 0; v < 6; v++) begin
      pulse_ev(8'(1 << pos_of(v)));
      chk("R2 set", flags, 32'(1 << pos_of(v)));
      wr_flags(8'h00);
      chk("R4 write zero keeps", flags, 32'(1 << pos_of(v)));
      wr_flags(~8'(1 << pos_of(v)));
      chk("R4 other bits keep", flags, 32'(1 << pos_of(v)));
      wr_flags(8'(1 << pos_of(v)));
      chk("R4 write one clears", flags, 8'h00);
    end

    // R1 reserved flags read zero
    pulse_ev(8'hFF);
    chk("R1 all flags", flags, 8'hEB);
    wr_flags(8'h14);
    chk("R1 reserved write no effect", flags, 8'hEB);
    wr_flags(8'hFF);
    chk("R4 clear all", flags, 8'h00);

    // R3 timer1 overflow source selection
    pwm_mode = 0;
    ev_t1_turn = 1; tick(); ev_t1_turn = 0;
    chk("R3 normal ignores turn", flags, 8'h00);
    ev_t1_wrap = 1; tick(); ev_t1_wrap = 0;
    chk("R3 normal wrap sets", flags, 8'h80);
    wr_flags(8'hFF);
    pwm_mode = 1;
    ev_t1_wrap = 1; tick(); ev_t1_wrap = 0;
    chk("R3 pwm ignores wrap", flags, 8'h00);
    ev_t1_turn = 1; tick(); ev_t1_turn = 0;
    chk("R3 pwm turn sets", flags, 8'h80);
    wr_flags(8'hFF);
    pwm_mode = 0;

    // R5 acknowledge clears only its flag
    pulse_ev(8'hFF);
    acc = 8'hEB;
    for (int v = 0; v < 6; v++) begin
      vec_ack = 6'(1 << v);
      tick();
      vec_ack = 6'h00;
      acc = acc & ~8'(1 << pos_of(v));
      chk("R5 ack", flags, acc);
    end

    // R6 set wins over clear
    for (int v = 0; v < 6; v++) begin
      drive_ev(8'(1 << pos_of(v)));
      flag_wr = 1; wr_data = 8'hFF;
      tick();
      drive_ev(8'h00); flag_wr = 0; wr_data = 8'h00;
      chk("R6 set beats write", flags, 32'(1 << pos_of(v)));
      drive_ev(8'(1 << pos_of(v)));
      vec_ack = 6'(1 << v);
      tick();
      drive_ev(8'h00); vec_ack = 6'h00;
      chk("R6 set beats ack", flags, 32'(1 << pos_of(v)));
      wr_flags(8'hFF);
    end

    // R7 / R8 exhaustive sweep of pending patterns
    for (int e = 0; e < 4; e++) begin
      logic [7:0] ens;
      case (e)
        0: ens = 8'hFF;
        1: ens = 8'h00;
        2: ens = 8'hA9;
        default: ens = 8'h42;
      endcase
      wr_en(ens);
      for (int p = 0; p < 64; p++) begin
        logic [7:0] fm;
        fm = 8'h00;
        for (int v = 0; v < 6; v++)
          if (p[v]) fm[pos_of(v)] = 1'b1;
        wr_flags(8'hFF);
        pulse_ev(fm);
        for (int g = 0; g < 2; g++) begin
          logic [7:0] exp_req;
          int win;
          gie = g[0];
          #1;
          exp_req = g[0] ? (fm & ens & 8'hEB) : 8'h00;
          win = -1;
          for (int v = 5; v >= 0; v--)
            if (exp_req[pos_of(v)]) win = v;
          chk("R7 req", irq_req, exp_req);
          chk("R8 pending", irq_pending, (win >= 0));
          if (win >= 0) chk("R8 vec", irq_vec, win);
        end
        gie = 0;
      end
    end

    // R9 reset mid-run
    wr_en(8'hFF);
    pulse_ev(8'hFF);
    rst = 1; tick(); rst = 0;
    chk("R9 flags after reset", flags, 8'h00);
    chk("R9 enables after reset", enables, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule